// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block produces the clock set needed by a serial audio master from one fast reference clock. A divider of the form 2 x DIV + ODD sets the base rate. In master-clock mode the base rate is sent out as a master clock at 256 times the sample rate, and the bit clock is an integer fraction of it. In direct mode the master clock output stays low and the bit clock runs at the base rate itself. Word select marks left and right channels, and a one-cycle strobe marks each channel boundary for the serial data logic that sits next to this block.

All outputs are registered in the reference clock domain and advance on internal strobes. Configuration is sampled while the block is disabled and is frozen while it runs. Each enable therefore starts a clean, fully defined sequence.

Top module: `aclk_gen`

## Requirements
- R1: While reset is asserted, mclkOut, wordSel and chanStrobe are 0 and bclkOut equals the cpol input.
- R2: The base period N in reference cycles is 2 x divVal + oddDiv, where a divVal of 0 or 1 counts as 2. With mclkEn set, mclkOut has period N and is high for floor(N/2) cycles, starting with the first clock edge at which enable is sampled high.
- R3: With mclkEn set, the bit clock period is 8N when chan32 is 0 (16-bit channels) and 4N when chan32 is 1 (32-bit channels). The active phase comes first and lasts half the period, so a full left/right frame is 256 master clocks.
- R4: With mclkEn clear, mclkOut stays 0 and the bit clock period is N, with an active phase of floor(N/2) cycles that starts at the first enabled edge.
- R5: cpol sets the idle level of bclkOut and the active phase is the opposite level. While disabled, bclkOut follows the cpol input.
- R6: wordSel starts at 0 after enable and toggles on the active-to-idle edge of the bit clock that ends every L-th bit period, where L is 16 when chan32 is 0 and 32 when it is 1.
- R7: chanStrobe is high for exactly one reference cycle, in the cycle in which wordSel toggles, and is 0 otherwise.
- R8: From the edge at which enable is sampled low, all outputs return to idle (mclkOut 0, bclkOut at cpol, wordSel 0, chanStrobe 0). A disable that lands on a channel boundary suppresses that boundary. The next enable starts again from a full first period.
- R9: divVal, oddDiv, mclkEn, chan32 and cpol are captured while enable is low. Changes made while enable is high have no effect on any output until the block has been disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; low holds all outputs idle |
| divVal | input | DIV_W | Linear divider value DIV |
| oddDiv | input | 1 | Adds one reference cycle to the base period |
| mclkEn | input | 1 | 1: master clock mode, 0: direct bit clock mode |
| chan32 | input | 1 | 0: 16-bit channels, 1: 32-bit channels |
| cpol | input | 1 | Idle level of the bit clock |
| mclkOut | output | 1 | Master clock |
| bclkOut | output | 1 | Bit clock |
| wordSel | output | 1 | Channel select, 0 for the left channel |
| chanStrobe | output | 1 | One-cycle pulse at each channel boundary |

## Verification
The channel boundary (the toggle of wordSel plus the strobe) can fall in the same reference cycle as a drop of enable. The bench runs a direct-mode, 16-bit setting with N = 4 and computes the cycle of the first boundary from the requirements. It drops enable so that the disabling edge is exactly that boundary edge. It then expects no strobe, wordSel at 0 and both clocks idle after that edge, and expects a clean restart on the next enable. The boundary always lands on a bit clock falling phase, so every run also compares wordSel and the bit clock level cycle by cycle against a model derived from R2 to R6.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;

  // Events handed from the sequencer to the output stage.
  typedef struct packed {
    logic run;       // block enabled this cycle
    logic baseRise;  // start of a base period
    logic baseFall;  // middle of a base period
    logic bitRise;   // start of a bit clock active phase
    logic bitFall;   // end of a bit clock active phase
    logic chanEnd;   // last bit of a channel finished
    logic mclkOn;    // captured master-clock mode
    logic cpolRun;   // captured idle level
  } clkStrobe_t;

endpackage

// File: rtl/aclk_ctrl.sv
`timescale 1ns/1ps
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DIV_MIN     = 2,
  parameter int unsigned RATIO_SHORT = 8,
  parameter int unsigned RATIO_LONG  = 4,
  parameter int unsigned CHAN_SHORT  = 16,
  parameter int unsigned CHAN_LONG   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic             oddDiv,
  input  logic             mclkEn,
  input  logic             chan32,
  input  logic             cpol,
  output clkStrobe_t       strobes
);

  localparam int unsigned CNT_W = DIV_W + 1;
  localparam int unsigned RATIO_MAX = (RATIO_SHORT > RATIO_LONG) ? RATIO_SHORT : RATIO_LONG;
  localparam int unsigned PH_W = (RATIO_MAX > 1) ? $clog2(RATIO_MAX) : 1;
  localparam int unsigned CHAN_MAX = (CHAN_SHORT > CHAN_LONG) ? CHAN_SHORT : CHAN_LONG;
  localparam int unsigned BC_W = $clog2(CHAN_MAX);

  // Captured configuration
  logic [DIV_W-1:0] divQ;
  logic             oddQ;
  logic             mclkQ;
  logic             longQ;
  logic             polQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ  <= '0;
      oddQ  <= 1'b0;
      mclkQ <= 1'b0;
      longQ <= 1'b0;
      polQ  <= 1'b0;
    end else if (!enable) begin
      divQ  <= divVal;
      oddQ  <= oddDiv;
      mclkQ <= mclkEn;
      longQ <= chan32;
      polQ  <= cpol;
    end
  end

  // Base period arithmetic
  logic [DIV_W-1:0] divEff;
  logic [CNT_W-1:0] periodN;
  logic [CNT_W-1:0] halfN;

  always_comb begin
    divEff  = (divQ < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : divQ;
    periodN = {divEff, 1'b0} + CNT_W'(oddQ);
    halfN   = periodN >> 1;
  end

  // Mode-dependent limits
  logic [PH_W-1:0] phLast;
  logic [PH_W-1:0] phHalf;
  logic [BC_W-1:0] bitLast;

  always_comb begin
    phLast  = longQ ? PH_W'(RATIO_LONG - 1) : PH_W'(RATIO_SHORT - 1);
    phHalf  = longQ ? PH_W'(RATIO_LONG / 2) : PH_W'(RATIO_SHORT / 2);
    bitLast = longQ ? BC_W'(CHAN_LONG - 1)  : BC_W'(CHAN_SHORT - 1);
  end

  // Counters
  logic [CNT_W-1:0] baseCnt;
  logic [PH_W-1:0]  bitPh;
  logic [BC_W-1:0]  bitCnt;

  logic baseRise;
  logic baseFall;
  logic bitRise;
  logic bitFall;
  logic chanEnd;

  always_comb begin
    baseRise = enable && (baseCnt == '0);
    baseFall = enable && (baseCnt == halfN);
    if (mclkQ) begin
      bitRise = baseRise && (bitPh == '0);
      bitFall = baseRise && (bitPh == phHalf);
    end else begin
      bitRise = baseRise;
      bitFall = baseFall;
    end
    chanEnd = bitFall && (bitCnt == bitLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
    end else if (!enable) begin
      baseCnt <= '0;
    end else if (baseCnt == periodN - 1'b1) begin
      baseCnt <= '0;
    end else begin
      baseCnt <= baseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPh <= '0;
    end else if (!enable) begin
      bitPh <= '0;
    end else if (baseRise && mclkQ) begin
      bitPh <= (bitPh == phLast) ? '0 : bitPh + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!enable) begin
      bitCnt <= '0;
    end else if (bitFall) begin
      bitCnt <= (bitCnt == bitLast) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.run      = enable;
    strobes.baseRise = baseRise;
    strobes.baseFall = baseFall;
    strobes.bitRise  = bitRise;
    strobes.bitFall  = bitFall;
    strobes.chanEnd  = chanEnd;
    strobes.mclkOn   = mclkQ;
    strobes.cpolRun  = polQ;
  end

  // R2: the base counter never reaches the period it wraps at
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (baseCnt < periodN));

  // R6: the bit counter stays within one channel
  a_r6_bitcnt_in_chan: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (bitCnt <= bitLast));

  // R9: captured configuration is frozen while running
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |->
      ($stable(divQ) && $stable(oddQ) && $stable(mclkQ) && $stable(longQ) && $stable(polQ)));

endmodule

// File: rtl/aclk_dp.sv
`timescale 1ns/1ps
module aclk_dp
  import aclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  clkStrobe_t strobes,
  input  logic       cpolLive,
  output logic       mclkOut,
  output logic       bclkOut,
  output logic       wordSel,
  output logic       chanStrobe
);

  logic runQ;
  logic mclkQ;
  logic rawQ;
  logic wsQ;
  logic strbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      mclkQ <= 1'b0;
      rawQ  <= 1'b0;
      wsQ   <= 1'b0;
      strbQ <= 1'b0;
    end else if (!strobes.run) begin
      runQ  <= 1'b0;
      mclkQ <= 1'b0;
      rawQ  <= 1'b0;
      wsQ   <= 1'b0;
      strbQ <= 1'b0;
    end else begin
      runQ <= 1'b1;
      if (strobes.baseRise && strobes.mclkOn) begin
        mclkQ <= 1'b1;
      end else if (strobes.baseFall) begin
        mclkQ <= 1'b0;
      end
      if (strobes.bitRise) begin
        rawQ <= 1'b1;
      end else if (strobes.bitFall) begin
        rawQ <= 1'b0;
      end
      if (strobes.chanEnd) begin
        wsQ <= ~wsQ;
      end
      strbQ <= strobes.chanEnd;
    end
  end

  logic polSel;
  assign polSel     = runQ ? strobes.cpolRun : cpolLive;
  assign mclkOut    = mclkQ;
  assign bclkOut    = rawQ ^ polSel;
  assign wordSel    = wsQ;
  assign chanStrobe = strbQ;

  // R7: a channel boundary coincides with the end of an active phase
  a_r7_strobe_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    chanStrobe |-> (!rawQ && $past(rawQ)));

  // R7: the boundary strobe lasts one reference cycle
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    chanStrobe |=> !chanStrobe);

  // R8: a disabled cycle leaves every output idle
  a_r8_idle_after_off: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> (!mclkOut && !rawQ && !wordSel && !chanStrobe));

  // R4: no master clock activity in direct mode
  a_r4_no_mclk_direct: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.mclkOn && !mclkOut) |=> !mclkOut);

endmodule

// File: rtl/aclk_gen.sv
`timescale 1ns/1ps
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DIV_MIN     = 2,
  parameter int unsigned RATIO_SHORT = 8,
  parameter int unsigned RATIO_LONG  = 4,
  parameter int unsigned CHAN_SHORT  = 16,
  parameter int unsigned CHAN_LONG   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic             oddDiv,
  input  logic             mclkEn,
  input  logic             chan32,
  input  logic             cpol,
  output logic             mclkOut,
  output logic             bclkOut,
  output logic             wordSel,
  output logic             chanStrobe
);

  clkStrobe_t strobes;

  aclk_ctrl #(
    .DIV_W      (DIV_W),
    .DIV_MIN    (DIV_MIN),
    .RATIO_SHORT(RATIO_SHORT),
    .RATIO_LONG (RATIO_LONG),
    .CHAN_SHORT (CHAN_SHORT),
    .CHAN_LONG  (CHAN_LONG)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .divVal (divVal),
    .oddDiv (oddDiv),
    .mclkEn (mclkEn),
    .chan32 (chan32),
    .cpol   (cpol),
    .strobes(strobes)
  );

  aclk_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpolLive  (cpol),
    .mclkOut   (mclkOut),
    .bclkOut   (bclkOut),
    .wordSel   (wordSel),
    .chanStrobe(chanStrobe)
  );

endmodule

// File: tb/test_aclk_gen.sv
`timescale 1ns/1ps
module test_aclk_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] divVal = 8'd2;
  logic       oddDiv = 1'b0;
  logic       mclkEn = 1'b0;
  logic       chan32 = 1'b0;
  logic       cpol = 1'b1;
  logic       mclkOut;
  logic       bclkOut;
  logic       wordSel;
  logic       chanStrobe;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  aclk_gen i_aclk_gen (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .divVal    (divVal),
    .oddDiv    (oddDiv),
    .mclkEn    (mclkEn),
    .chan32    (chan32),
    .cpol      (cpol),
    .mclkOut   (mclkOut),
    .bclkOut   (bclkOut),
    .wordSel   (wordSel),
    .chanStrobe(chanStrobe)
  );

  task automatic expectBit(string req, string what, int t, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
    end
  endtask

  function automatic int effN(int dv, int od);
    return 2 * ((dv < 2) ? 2 : dv) + od;
  endfunction

  // Expected {mclk, bclk, ws, strobe} t cycles after the first enabled edge
  function automatic logic [3:0] model(int t, int n, bit m, bit c32, bit pol);
    int ratio = c32 ? 4 : 8;
    int len = c32 ? 32 : 16;
    int p = m ? n * ratio : n;
    int fo = m ? p / 2 : n / 2;
    int j = (t >= fo) ? (t - fo) / p + 1 : 0;
    logic mc = m && ((t % n) < n / 2);
    logic raw = (t % p) < fo;
    logic ws = ((j / len) % 2) == 1;
    logic st = (t >= fo) && ((t - fo) % p == 0) && (j % len == 0);
    return {mc, raw ^ pol, ws, st};
  endfunction

  task automatic checkIdle(string req, int t, logic pol);
    expectBit(req, "mclkOut idle", t, mclkOut, 1'b0);
    expectBit(req, "bclkOut idle", t, bclkOut, pol);
    expectBit(req, "wordSel idle", t, wordSel, 1'b0);
    expectBit(req, "chanStrobe idle", t, chanStrobe, 1'b0);
  endtask

  task automatic checkCycle(string req, int t, logic [3:0] exp);
    expectBit(req, "mclkOut", t, mclkOut, exp[3]);
    expectBit(req, "bclkOut", t, bclkOut, exp[2]);
    expectBit(req, "wordSel", t, wordSel, exp[1]);
    expectBit(req, "chanStrobe", t, chanStrobe, exp[0]);
  endtask

  // Configure, enable, compare len cycles, then disable and check idle.
  // When freezeAt >= 0 the live inputs are scrambled after that sample.
  task automatic runCase(string req, int dv, int od, bit m, bit c32, bit pol,
                         int len, int freezeAt);
    int n = effN(dv, od);
    @(negedge clk);
    enable = 1'b0;
    divVal = 8'(dv);
    oddDiv = od[0];
    mclkEn = m;
    chan32 = c32;
    cpol   = pol;
    @(negedge clk);
    checkIdle("R5", -1, pol);
    enable = 1'b1;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      checkCycle(req, t, model(t, n, m, c32, pol));
      if (t == freezeAt) begin
        divVal = 8'd9;
        oddDiv = ~oddDiv;
        mclkEn = ~mclkEn;
        chan32 = ~chan32;
        cpol   = ~cpol;
      end
    end
    enable = 1'b0;
    @(negedge clk);
    checkIdle("R8", len, cpol);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkIdle("R1", -1, 1'b1);
    cpol = 1'b0;
    @(negedge clk);
    checkIdle("R1", -1, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1", -1, 1'b0);
  endtask

  // R3 with R2 and R6/R7: master clock mode, 16-bit, N=4, two boundaries
  task automatic testMclk16();
    runCase("R2/R3/R6/R7", 2, 0, 1'b1, 1'b0, 1'b0, 1100, -1);
  endtask

  // R3 and R5: master clock mode, 32-bit, odd N=7, idle level high
  task automatic testMclk32Odd();
    runCase("R3/R5/R6/R7", 3, 1, 1'b1, 1'b1, 1'b1, 950, -1);
  endtask

  // R4: direct mode, 16-bit, odd N=11
  task automatic testDirect16();
    runCase("R4/R6/R7", 5, 1, 1'b0, 1'b0, 1'b0, 400, -1);
  endtask

  // R2: divider values 0 and 1 behave as 2
  task automatic testMinDiv();
    runCase("R2/R4", 0, 0, 1'b0, 1'b1, 1'b1, 300, -1);
    runCase("R2/R3", 1, 1, 1'b1, 1'b0, 1'b0, 200, -1);
  endtask

  // R9: live inputs scrambled mid-run must not change anything
  task automatic testFrozen();
    runCase("R9", 2, 0, 1'b1, 1'b0, 1'b0, 600, 40);
  endtask

  // R8: disable lands exactly on the first channel boundary (t=62 for
  // direct mode, N=4, 16-bit), then restart from a full period
  task automatic testDisableAtBoundary();
    runCase("R8", 2, 0, 1'b0, 1'b0, 1'b0, 62, -1);
    runCase("R8/R6", 2, 0, 1'b0, 1'b0, 1'b0, 140, -1);
  endtask

  initial begin
    testReset();
    testMclk16();
    testMclk32Odd();
    testDirect16();
    testMinDiv();
    testFrozen();
    testDisableAtBoundary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule